// File: doc/BRIEF.md
# Open-Row-Priority Request Picker

This block chooses which pending DRAM request a controller should issue next. The surrounding queue shows the picker its slots in age order, with slot 0 the oldest. Each slot has a valid flag, a rank, a bank and a row. From outside the block the picker also receives, for every bank, the row that is currently open and the cycle at which that bank can next accept a command. It also receives the current cycle count and a mask that marks the earliest-available banks. A separate block produces that mask.

A policy input selects between two schemes. Plain arrival order issues the oldest valid slot. Open-row priority first looks for a request that hits an open row. If there is none, it takes the oldest request whose bank is ready now or is marked as earliest-available. If still nothing qualifies, it takes the oldest valid slot so the controller always makes progress. The result is registered: one cycle after a decision is requested, the chosen slot index appears together with a one-cycle grant. The read queue and the write queue each use their own instance of the same picker.

Top module: `rsel_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `grant` is 0 and `sel_idx` is 0.
- R2: With `policy`=0 (arrival order), the picker selects the lowest-numbered valid slot. Slot 0 is the oldest.
- R3: With `policy`=1 (open-row priority), the picker selects the lowest-numbered valid slot whose row equals the open row of that slot's bank, if any such slot exists.
- R4: A slot's global bank number is rank × `BANKS_PER_RANK` + bank. Field g of `bank_open_row` and `bank_ready_at`, and bit g of `early_mask`, belong to global bank g. For example, with 4 banks per rank, rank 1 bank 0 is bank 4.
- R5: Under `policy`=1 with no row hit, the picker selects the lowest-numbered valid slot whose bank's ready cycle is less than or equal to `now`.
- R6: In the R5 fallback, a slot also qualifies when the `early_mask` bit of its bank is set.
- R7: Under `policy`=1, if no slot is a row hit or qualifies under R5 or R6, the picker selects the lowest-numbered valid slot.
- R8: `mask_req` is high exactly when `policy`=1, at least one slot is valid and no valid slot is a row hit. When a row hit exists, `early_mask` has no effect on the choice.
- R9: A cycle with `decide`=1 and at least one valid slot produces `grant`=1 and the chosen index on `sel_idx` in the next cycle. With `decide`=0, `grant` is 0 next cycle and `sel_idx` keeps its value.
- R10: A cycle with `decide`=1 and no valid slot gives `grant`=0 and `sel_idx`=0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| policy | input | 1 | 0 = arrival order, 1 = open-row priority |
| decide | input | 1 | Request a selection this cycle |
| ent_valid | input | ENTRIES | Slot valid flags, bit 0 oldest |
| ent_rank | input | ENTRIES*RANK_W | Rank of each slot |
| ent_bank | input | ENTRIES*BANK_W | Bank within rank of each slot |
| ent_row | input | ENTRIES*ROW_W | Row of each slot |
| bank_open_row | input | NB*ROW_W | Open row of each global bank |
| bank_ready_at | input | NB*TIME_W | Cycle at which each global bank is free |
| now | input | TIME_W | Current cycle count |
| early_mask | input | NB | Earliest-available bank mask |
| mask_req | output | 1 | Availability mask is needed (no row hit) |
| sel_idx | output | IDX_W | Registered index of the chosen slot |
| grant | output | 1 | One-cycle strobe for a fresh selection |

## Verification
The assertions assume that every slot's rank is below `RANKS` and its bank below `BANKS_PER_RANK`, so that every global bank number points at a real bank. They also assume that the inputs are held steady for the whole cycle in which `decide` is sampled. The stimulus draws ranks and banks only from these legal ranges and changes inputs only on the falling edge. It keeps rows and ready times in narrow ranges, so row hits, ready banks and mask-only qualifiers all occur often in the random phase.

// File: rtl/rsel_pkg.sv
// Shared types for the request picker.
// Assumes: nothing beyond the two policy encodings below.
package rsel_pkg;
    typedef enum logic {
        POL_ARRIVAL = 1'b0,
        POL_OPENROW = 1'b1
    } sched_pol_e;
endpackage

// File: rtl/rsel_bank_map.sv
// Maps each slot's (rank, bank) pair onto a flat global bank number.
// Assumes: rank < RANKS and bank < BANKS_PER_RANK for every slot.
module rsel_bank_map #(
    parameter int ENTRIES        = 8,
    parameter int BANKS_PER_RANK = 4,
    parameter int RANK_W         = 1,
    parameter int BANK_W         = 2,
    parameter int ID_W           = 3
) (
    input  logic [ENTRIES*RANK_W-1:0] ent_rank,
    input  logic [ENTRIES*BANK_W-1:0] ent_bank,
    output logic [ENTRIES*ID_W-1:0]   ent_gid
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_map
        // Global number = rank * banks per rank + bank (R4)
        always_comb begin
            ent_gid[e*ID_W +: ID_W] =
                ID_W'(ent_rank[e*RANK_W +: RANK_W]) * ID_W'(BANKS_PER_RANK)
                + ID_W'(ent_bank[e*BANK_W +: BANK_W]);
        end
    end
endmodule

// File: rtl/rsel_qualify.sv
// Flags, per slot, whether it hits its bank's open row and whether its bank
// qualifies as available (ready now or marked earliest-available).
// Assumes: every global bank number is below NB.
module rsel_qualify #(
    parameter int ENTRIES = 8,
    parameter int NB      = 8,
    parameter int ID_W    = 3,
    parameter int ROW_W   = 12,
    parameter int TIME_W  = 16
) (
    input  logic [ENTRIES-1:0]       ent_valid,
    input  logic [ENTRIES*ID_W-1:0]  ent_gid,
    input  logic [ENTRIES*ROW_W-1:0] ent_row,
    input  logic [NB*ROW_W-1:0]      bank_open_row,
    input  logic [NB*TIME_W-1:0]     bank_ready_at,
    input  logic [TIME_W-1:0]        now,
    input  logic [NB-1:0]            early_mask,
    output logic [ENTRIES-1:0]       hit_vec,
    output logic [ENTRIES-1:0]       avail_vec
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_q
        logic [ID_W-1:0]   gid;
        logic [ROW_W-1:0]  open_row;
        logic [TIME_W-1:0] ready_at;
        logic              mask_bit;

        // Look up the per-bank state addressed by this slot
        always_comb begin
            gid      = ent_gid[e*ID_W +: ID_W];
            open_row = '0;
            ready_at = '0;
            mask_bit = 1'b0;
            for (int b = 0; b < NB; b++) begin
                if (gid == ID_W'(b)) begin
                    open_row = bank_open_row[b*ROW_W +: ROW_W];
                    ready_at = bank_ready_at[b*TIME_W +: TIME_W];
                    mask_bit = early_mask[b];
                end
            end
        end

        // Row hit and availability flags for this slot
        always_comb begin
            hit_vec[e]   = ent_valid[e] && (ent_row[e*ROW_W +: ROW_W] == open_row);
            avail_vec[e] = ent_valid[e] && ((ready_at <= now) || mask_bit);
        end
    end
endmodule

// File: rtl/rsel_first.sv
// Finds the lowest-numbered set bit (the oldest requesting slot).
// Assumes: bit 0 is the oldest position.
module rsel_first #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic [ENTRIES-1:0] req,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    // Scan youngest to oldest so the oldest set bit wins
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    always_comb begin
        AST_FIRST_IS_SET: assert (!found || req[idx]); // R2
    end
endmodule

// File: rtl/rsel_top.sv
// Chooses the next DRAM request under arrival order or open-row priority
// and registers the choice with a one-cycle grant.
// Assumes: slot 0 is the oldest; inputs are stable around the sampling edge.
module rsel_top #(
    parameter int ENTRIES        = 8,
    parameter int RANKS          = 2,
    parameter int BANKS_PER_RANK = 4,
    parameter int ROW_W          = 12,
    parameter int TIME_W         = 16,
    localparam int NB            = RANKS * BANKS_PER_RANK,
    localparam int RANK_W        = (RANKS > 1) ? $clog2(RANKS) : 1,
    localparam int BANK_W        = (BANKS_PER_RANK > 1) ? $clog2(BANKS_PER_RANK) : 1,
    localparam int ID_W          = (NB > 1) ? $clog2(NB) : 1,
    localparam int IDX_W         = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      policy,
    input  logic                      decide,
    input  logic [ENTRIES-1:0]        ent_valid,
    input  logic [ENTRIES*RANK_W-1:0] ent_rank,
    input  logic [ENTRIES*BANK_W-1:0] ent_bank,
    input  logic [ENTRIES*ROW_W-1:0]  ent_row,
    input  logic [NB*ROW_W-1:0]       bank_open_row,
    input  logic [NB*TIME_W-1:0]      bank_ready_at,
    input  logic [TIME_W-1:0]         now,
    input  logic [NB-1:0]             early_mask,
    output logic                      mask_req,
    output logic [IDX_W-1:0]          sel_idx,
    output logic                      grant
);
    import rsel_pkg::*;

    sched_pol_e             pol;
    logic [ENTRIES*ID_W-1:0] ent_gid;
    logic [ENTRIES-1:0]      hit_vec, avail_vec;
    logic                    any_hit, any_avail, any_valid;
    logic [IDX_W-1:0]        hit_idx, avail_idx, old_idx, pick_idx;

    assign pol = sched_pol_e'(policy);

    rsel_bank_map #(
        .ENTRIES(ENTRIES), .BANKS_PER_RANK(BANKS_PER_RANK),
        .RANK_W(RANK_W), .BANK_W(BANK_W), .ID_W(ID_W)
    ) u_map (
        .ent_rank(ent_rank), .ent_bank(ent_bank), .ent_gid(ent_gid)
    );

    rsel_qualify #(
        .ENTRIES(ENTRIES), .NB(NB), .ID_W(ID_W), .ROW_W(ROW_W), .TIME_W(TIME_W)
    ) u_qual (
        .ent_valid(ent_valid), .ent_gid(ent_gid), .ent_row(ent_row),
        .bank_open_row(bank_open_row), .bank_ready_at(bank_ready_at),
        .now(now), .early_mask(early_mask),
        .hit_vec(hit_vec), .avail_vec(avail_vec)
    );

    rsel_first #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_hit (
        .req(hit_vec), .found(any_hit), .idx(hit_idx)
    );
    rsel_first #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_avail (
        .req(avail_vec), .found(any_avail), .idx(avail_idx)
    );
    rsel_first #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_old (
        .req(ent_valid), .found(any_valid), .idx(old_idx)
    );

    // Mask is only needed when open-row priority finds no hit
    always_comb begin
        mask_req = (pol == POL_OPENROW) && any_valid && !any_hit;
    end

    // Policy mux: hit, then available bank, then oldest
    always_comb begin
        if (pol == POL_ARRIVAL)  pick_idx = old_idx;
        else if (any_hit)        pick_idx = hit_idx;
        else if (any_avail)      pick_idx = avail_idx;
        else                     pick_idx = old_idx;
    end

    // Register the choice and pulse grant for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_idx <= '0;
            grant   <= 1'b0;
        end else begin
            grant <= decide && any_valid;
            if (decide) sel_idx <= any_valid ? pick_idx : '0;
        end
    end

    always_comb begin
        if (rst_n) begin
            AST_PICK_IS_VALID: assert (!any_valid || ent_valid[pick_idx]); // R7
            AST_HIT_WINS: assert (!(pol == POL_OPENROW && any_hit) || hit_vec[pick_idx]); // R3
            AST_MASK_NOT_ON_HIT: assert (!(mask_req && any_hit)); // R8
        end
    end

    AST_GRANT_FROM_DECIDE: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> $past(decide)); // R9
    AST_HOLD_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        !decide |=> (!grant && $stable(sel_idx))); // R9
    AST_EMPTY_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && !any_valid) |=> (!grant && sel_idx == '0)); // R10
    AST_ARRIVAL_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && pol == POL_ARRIVAL && ent_valid[0]) |=> (grant && sel_idx == '0)); // R2
endmodule

// File: tb/sim_rsel_top.sv
`timescale 1ns/1ps
module sim_rsel_top;
    localparam int N = 8, RANKS = 2, BPR = 4, ROW_W = 12, TIME_W = 16;
    localparam int NB = RANKS * BPR;
    localparam int RANK_W = 1, BANK_W = 2, IDX_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic policy = 1'b0, decide = 1'b0;
    logic [N-1:0]        ent_valid = '0;
    logic [N*RANK_W-1:0] ent_rank = '0;
    logic [N*BANK_W-1:0] ent_bank = '0;
    logic [N*ROW_W-1:0]  ent_row = '0;
    logic [NB*ROW_W-1:0] bank_open_row = '0;
    logic [NB*TIME_W-1:0] bank_ready_at = '0;
    logic [TIME_W-1:0]   now = '0;
    logic [NB-1:0]       early_mask = '0;
    logic mask_req, grant;
    logic [IDX_W-1:0] sel_idx;

    int v[N], rk[N], bk[N], rw[N], orow[NB], rdy[NB];
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    rsel_top u0 (
        .clk(clk), .rst_n(rst_n), .policy(policy), .decide(decide),
        .ent_valid(ent_valid), .ent_rank(ent_rank), .ent_bank(ent_bank),
        .ent_row(ent_row), .bank_open_row(bank_open_row),
        .bank_ready_at(bank_ready_at), .now(now), .early_mask(early_mask),
        .mask_req(mask_req), .sel_idx(sel_idx), .grant(grant)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pack();
        for (int e = 0; e < N; e++) begin
            ent_valid[e] = v[e][0];
            ent_rank[e*RANK_W +: RANK_W] = RANK_W'(rk[e]);
            ent_bank[e*BANK_W +: BANK_W] = BANK_W'(bk[e]);
            ent_row[e*ROW_W +: ROW_W] = ROW_W'(rw[e]);
        end
        for (int b = 0; b < NB; b++) begin
            bank_open_row[b*ROW_W +: ROW_W] = ROW_W'(orow[b]);
            bank_ready_at[b*TIME_W +: TIME_W] = TIME_W'(rdy[b]);
        end
    endtask

    function automatic int gbank(input int e);
        return rk[e] * BPR + bk[e];
    endfunction

    function automatic int hit_exists();
        for (int e = 0; e < N; e++)
            if (v[e] != 0 && rw[e] == orow[gbank(e)]) return 1;
        return 0;
    endfunction

    function automatic int ref_pick(input int pol);
        int oldest = -1;
        for (int e = N - 1; e >= 0; e--) if (v[e] != 0) oldest = e;
        if (oldest < 0) return 0;
        if (pol == 0) return oldest;
        for (int e = 0; e < N; e++)
            if (v[e] != 0 && rw[e] == orow[gbank(e)]) return e;
        for (int e = 0; e < N; e++)
            if (v[e] != 0 && (rdy[gbank(e)] <= int'(now) || early_mask[gbank(e)])) return e;
        return oldest;
    endfunction

    function automatic int any_v();
        for (int e = 0; e < N; e++) if (v[e] != 0) return 1;
        return 0;
    endfunction

    // One decision: drive at falling edge, check the registered result next falling edge
    task automatic decide_and_check(input int pol, input string req);
        int exp_idx, exp_g, exp_m;
        @(negedge clk);
        policy = pol[0];
        pack();
        decide = 1'b1;
        exp_idx = ref_pick(pol);
        exp_g = any_v();
        exp_m = (pol == 1 && exp_g == 1 && hit_exists() == 0) ? 1 : 0;
        #1;
        check("R8 mask_req", int'(mask_req), exp_m);
        @(negedge clk);
        decide = 1'b0;
        check({req, " grant"}, int'(grant), exp_g);
        check({req, " sel_idx"}, int'(sel_idx), exp_idx);
    endtask

    task automatic clear_all();
        for (int e = 0; e < N; e++) begin v[e] = 0; rk[e] = 0; bk[e] = 0; rw[e] = 0; end
        for (int b = 0; b < NB; b++) begin orow[b] = 100; rdy[b] = 1000; end
        now = 16'd10;
        early_mask = '0;
    endtask

    initial begin
        #(8 * 200000);
        errors++; checks++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int prev;
        void'($urandom(32'd1234));
        clear_all();
        pack();
        repeat (3) @(negedge clk);
        check("R1 grant in reset", int'(grant), 0);
        check("R1 sel_idx in reset", int'(sel_idx), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 grant after reset", int'(grant), 0);
        check("R1 sel_idx after reset", int'(sel_idx), 0);

        // R10: empty queue
        clear_all();
        decide_and_check(1, "R10 empty");

        // R2: arrival order skips invalid head, ignores a younger hit
        clear_all();
        v[2] = 1; v[5] = 1; rk[5] = 1; bk[5] = 1; rw[5] = 100;
        decide_and_check(0, "R2 arrival");

        // R3: younger row hit beats older miss
        clear_all();
        v[0] = 1; rw[0] = 7; v[3] = 1; v[6] = 1;
        rk[3] = 0; bk[3] = 2; rw[3] = 100;
        decide_and_check(1, "R3 hit");

        // R4: rank 1 bank 0 maps to bank 4
        clear_all();
        for (int b = 0; b < NB; b++) orow[b] = 1;
        orow[4] = 9;
        v[1] = 1; rk[1] = 0; bk[1] = 0; rw[1] = 9;
        v[4] = 1; rk[4] = 1; bk[4] = 0; rw[4] = 9;
        decide_and_check(1, "R4 bank map");

        // R5: no hit, oldest with ready bank
        clear_all();
        v[1] = 1; bk[1] = 1; v[3] = 1; bk[3] = 3; rdy[3] = 10; v[7] = 1; bk[7] = 2; rdy[2] = 0;
        decide_and_check(1, "R5 ready");

        // R6: mask bit alone qualifies
        clear_all();
        v[0] = 1; bk[0] = 1; v[2] = 1; rk[2] = 1; bk[2] = 2; early_mask[6] = 1'b1;
        decide_and_check(1, "R6 mask");

        // R7: nothing qualifies, oldest valid
        clear_all();
        v[3] = 1; v[4] = 1; bk[4] = 2;
        decide_and_check(1, "R7 oldest");

        // R8: a full mask must not beat a hit
        clear_all();
        v[0] = 1; bk[0] = 1; rdy[1] = 0; v[5] = 1; bk[5] = 2; rw[5] = 100;
        early_mask = '1;
        decide_and_check(1, "R8 hit over mask");

        // R9: no decide holds index and drops grant
        prev = int'(sel_idx);
        @(negedge clk);
        check("R9 hold grant", int'(grant), 0);
        check("R9 hold sel_idx", int'(sel_idx), prev);

        // Random mix of both policies
        for (int t = 0; t < 300; t++) begin
            for (int e = 0; e < N; e++) begin
                v[e] = ($urandom % 3 != 0) ? 1 : 0;
                rk[e] = $urandom % RANKS; bk[e] = $urandom % BPR; rw[e] = $urandom % 4;
            end
            for (int b = 0; b < NB; b++) begin
                orow[b] = ($urandom % 6); rdy[b] = $urandom % 128;
            end
            now = TIME_W'($urandom % 64);
            early_mask = NB'($urandom % 4 == 0 ? $urandom : 0);
            decide_and_check(int'($urandom % 2), "R3 R5 R6 R7 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule